// File: doc/BRIEF.md
# SPI Serial Port

This block is a byte-wide SPI port that a CPU controls through three registers on a small synchronous bus. It can act as bus master, driving the serial clock itself at one quarter of the system clock, or as a slave, following an external serial clock that it resynchronises into the system clock domain. Bytes move most significant bit first. The data register sits in front of an internal shift register that the CPU cannot reach directly.

Three settings describe the wire timing. The first is the idle level of the serial clock. The second is the clock edge that launches the next transmit bit. The third applies in master mode only and chooses whether incoming data is captured halfway through each bit or at its end. Receive is double-buffered: a completed byte is copied into the data register and raises a buffer-full flag and an interrupt flag. Transmit is single-buffered: a CPU write goes to the data register and to the shift register at once.

The register map is: address 0 is control, address 1 is status, address 2 is data, and address 3 reads zero. Control bits are en [0], master [1], cpol [2], ovf [3], irq [4], and three spare storage bits [7:5]. Status bits are smp [7], cke [6], bits [5:1] reading zero, and the buffer-full flag bf [0].

Top module: `spi_port`

## Requirements
- R1: After a synchronous reset, all three registers read 0x00, irq is 0, sck_o is 0 and sdo is 0.
- R2: The control register reads back exactly what was written. In the status register only bits 7 and 6 are writable. Bits 5:1 always read 0, and a write does not change bit 0 (bf).
- R3: When no master transfer is running, sck_o equals cpol. A transfer starts only on a data write while en=1, master=1 and no transfer is running. It lasts 32 system clocks, 4 per bit, with the bits sent most significant first. With en=0 a data write starts nothing.
- R4: In master mode with cke=1, SCK stays at the idle level for the first two clocks of each bit and is active for the last two, so sdo changes on the active-to-idle transition. With cke=0, SCK is active for the first two clocks and idle for the last two.
- R5: In master mode with smp=0, sdi is captured at the end of the second clock of each bit (mid-bit). With smp=1, it is captured at the end of the fourth clock (end of bit).
- R6: In slave mode, sck_i and sdi pass through a two-stage synchroniser. Data is captured on the edge that does not launch data, whatever the value of smp. sdo advances on each launch edge except the first launch edge of a byte with cke=0. A byte completes on the eighth capture edge.
- R7: When a byte completes and bf is 0, the byte goes into the data register, and bf and irq become 1 at the same clock edge.
- R8: A CPU read of the data register clears bf. irq stays set until the CPU writes 0 to control bit 4, and reads have no effect on it.
- R9: When a byte completes while bf is 1, the data register keeps its contents and the sticky ovf bit (control bit 3) is set. The bit stays set until the CPU writes 0 to it.
- R10: A data write loads both the data register and the shift register, and sdo shows bit 7 of the written value one clock later. A data write made while a master transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 data) |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe; a read of the data register clears bf |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register selected by bus_addr |
| irq | output | 1 | Interrupt flag (control bit 4) |
| sck_i | input | 1 | Serial clock from the master, used in slave mode |
| sck_o | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | High when the port drives the serial clock (en and master) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, the shift register MSB |

## Verification
The bench uses the default parameters: a divider of 4 and two synchroniser stages. With these values a master byte takes 32 clocks, so the bench's behavioural model can predict sck_o and sdo on every single clock, under both polarities and both launch edges. The bench drives sdi with one value in the first half of each bit and another value in the second half, so the captured byte shows directly whether mid-bit or end-of-bit capture was used. In the slave runs, the bench drives sck_i with half-periods of eight clocks. This is long enough for the two-stage synchroniser, and it lets the bench check sdo before every capture edge under both clock-edge settings.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int unsigned REG_W = 8;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [2:0] spare;
        logic       irq;
        logic       ovf;
        logic       cpol;
        logic       master;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic smp;
        logic cke;
    } cfg_t;

    // SCK is in its active state during the first half of a bit when cke=0,
    // and during the second half when cke=1.
    function automatic logic sck_active(input logic first_half, input logic cke);
        return cke ? !first_half : first_half;
    endfunction

endpackage

// File: rtl/spi_port_regs.sv
module spi_port_regs
    import spi_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic             busy,
    input  logic             rx_done,
    input  logic [REG_W-1:0] rx_byte,
    output ctrl_t            ctrl,
    output cfg_t             cfg,
    output logic             bf,
    output logic [REG_W-1:0] dbuf,
    output logic             tx_load
);

    reg_addr_e sel;
    logic      wr_ctrl, wr_stat, wr_data, rd_data;

    assign sel     = reg_addr_e'(addr);
    assign wr_ctrl = wr && (sel == A_CTRL);
    assign wr_stat = wr && (sel == A_STAT);
    assign wr_data = wr && (sel == A_DATA) && !busy;
    assign rd_data = rd && (sel == A_DATA);
    assign tx_load = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            cfg  <= '0;
            bf   <= 1'b0;
            dbuf <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata);
            if (wr_stat) cfg  <= cfg_t'(wdata[REG_W-1:REG_W-2]);
            if (wr_data) dbuf <= wdata;
            if (rd_data) bf   <= 1'b0;
            // a completing byte takes precedence over a CPU write in the same clock
            if (rx_done) begin
                ctrl.irq <= 1'b1;
                if (bf) begin
                    ctrl.ovf <= 1'b1;
                end else begin
                    dbuf <= rx_byte;
                    bf   <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (sel)
            A_CTRL:  rdata = ctrl;
            A_STAT:  rdata = {cfg, {(REG_W-3){1'b0}}, bf};
            A_DATA:  rdata = dbuf;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
    import spi_port_pkg::*;
#(
    parameter int unsigned DIV    = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic start,
    input  logic cke,
    input  logic cpol,
    output logic sck_o,
    output logic busy,
    output logic mid_stb,
    output logic end_stb,
    output logic last_bit
);

    localparam int unsigned PW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned BW   = $clog2(DATA_W);
    localparam int unsigned HALF = DIV / 2;

    logic [PW-1:0] ph_q;
    logic [BW-1:0] bit_q;
    logic          busy_q;
    logic          ph_wrap;

    assign ph_wrap = (ph_q == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy_q <= 1'b0;
            ph_q   <= '0;
            bit_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                ph_q   <= '0;
                bit_q  <= '0;
            end
        end else if (ph_wrap) begin
            ph_q <= '0;
            if (bit_q == BW'(DATA_W - 1)) begin
                busy_q <= 1'b0;
                bit_q  <= '0;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign busy     = busy_q;
    assign sck_o    = cpol ^ (busy_q && sck_active(ph_q < PW'(HALF), cke));
    assign mid_stb  = busy_q && (ph_q == PW'(HALF - 1));
    assign end_stb  = busy_q && ph_wrap;
    assign last_bit = (bit_q == BW'(DATA_W - 1));

endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter
    import spi_port_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              master,
    input  logic              cpol,
    input  logic              cke,
    input  logic              smp,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              mid_stb,
    input  logic              end_stb,
    input  logic              last_bit,
    input  logic              sck_i,
    input  logic              sdi,
    output logic              sdo,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int unsigned BW = $clog2(DATA_W);

    logic [SYNC-1:0]   sck_sync, sdi_sync;
    logic              sck_s, sdi_s, sck_prev;
    logic [DATA_W-1:0] sh_q;
    logic              samp_q, pend_q;
    logic [BW-1:0]     cnt_q;
    logic              slave_on, master_on, chg, to_active, to_idle;
    logic              s_samp, s_launch, s_last, in_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sync <= '0;
            sdi_sync <= '0;
        end else begin
            sck_sync <= {sck_sync[SYNC-2:0], sck_i};
            sdi_sync <= {sdi_sync[SYNC-2:0], sdi};
        end
    end

    assign sck_s     = sck_sync[SYNC-1];
    assign sdi_s     = sdi_sync[SYNC-1];
    assign slave_on  = en && !master;
    assign master_on = en && master;
    assign chg       = sck_s ^ sck_prev;
    assign to_active = chg && (sck_s != cpol);
    assign to_idle   = chg && (sck_s == cpol);
    assign s_samp    = slave_on && (cke ? to_active : to_idle);
    assign s_launch  = slave_on && (cke ? to_idle : to_active);
    assign s_last    = (cnt_q == BW'(DATA_W - 1));
    // master: end-of-bit capture takes sdi live, mid-bit uses the held sample
    assign in_bit    = master ? (smp ? sdi : samp_q) : sdi_s;
    assign rx_byte   = {sh_q[DATA_W-2:0], in_bit};
    assign rx_done   = (master_on && end_stb && last_bit) || (s_samp && s_last);
    assign sdo       = sh_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
            sh_q     <= '0;
            samp_q   <= 1'b0;
            pend_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            sck_prev <= sck_s;
            if (load) begin
                sh_q   <= load_byte;
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (!en) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (master) begin
                if (mid_stb) samp_q <= sdi;
                if (end_stb) sh_q   <= rx_byte;
            end else if (s_samp) begin
                samp_q <= sdi_s;
                if (s_last) begin
                    sh_q   <= rx_byte;
                    cnt_q  <= '0;
                    pend_q <= 1'b0;
                end else begin
                    cnt_q  <= cnt_q + 1'b1;
                    pend_q <= 1'b1;
                end
            end else if (s_launch && pend_q) begin
                sh_q   <= {sh_q[DATA_W-2:0], samp_q};
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int unsigned DIV  = 4,
    parameter int unsigned SYNC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             sdi,
    output logic             sdo
);

    ctrl_t            ctrl;
    cfg_t             cfg;
    logic             bf, busy, rx_done, tx_load;
    logic             mid_stb, end_stb, last_bit;
    logic [REG_W-1:0] dbuf, rx_byte;

    spi_port_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .busy    (busy),
        .rx_done (rx_done),
        .rx_byte (rx_byte),
        .ctrl    (ctrl),
        .cfg     (cfg),
        .bf      (bf),
        .dbuf    (dbuf),
        .tx_load (tx_load)
    );

    spi_port_clkgen #(.DIV(DIV), .DATA_W(REG_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.en && ctrl.master),
        .start    (tx_load),
        .cke      (cfg.cke),
        .cpol     (ctrl.cpol),
        .sck_o    (sck_o),
        .busy     (busy),
        .mid_stb  (mid_stb),
        .end_stb  (end_stb),
        .last_bit (last_bit)
    );

    spi_port_shifter #(.DATA_W(REG_W), .SYNC(SYNC)) u_shifter (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .master    (ctrl.master),
        .cpol      (ctrl.cpol),
        .cke       (cfg.cke),
        .smp       (cfg.smp),
        .load      (tx_load),
        .load_byte (bus_wdata),
        .mid_stb   (mid_stb),
        .end_stb   (end_stb),
        .last_bit  (last_bit),
        .sck_i     (sck_i),
        .sdi       (sdi),
        .sdo       (sdo),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte)
    );

    assign irq    = ctrl.irq;
    assign sck_oe = ctrl.en && ctrl.master;

endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       sck_o,
    input logic       rx_done,
    input logic       bf,
    input logic       tx_load,
    input logic       sdo,
    input logic       cpol,
    input logic       irq,
    input logic       ovf,
    input logic [7:0] dbuf,
    input logic       wdata_msb,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck_o == cpol));

    // R7
    rx_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !bf) |=> (bf && irq));

    // R9
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && bf && !tx_load) |=> (ovf && $stable(dbuf)));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2 && !rx_done) |=> !bf);

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(bus_wr && bus_addr == 2'd0)) |=> irq);

    // R10
    load_msb_chk: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (sdo == $past(wdata_msb)));

endmodule

bind spi_port spi_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .sck_o     (sck_o),
    .rx_done   (rx_done),
    .bf        (bf),
    .tx_load   (tx_load),
    .sdo       (sdo),
    .cpol      (ctrl.cpol),
    .irq       (ctrl.irq),
    .ovf       (ctrl.ovf),
    .dbuf      (dbuf),
    .wdata_msb (bus_wdata[7]),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd)
);

// File: tb/test_spi_port.sv
module test_spi_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, sck_o, sck_oe, sdo, sdi;
    logic       sck_i = 1'b0;
    logic       slv_sdi = 1'b0;
    logic       sdi_m = 1'b0;

    int errors = 0;
    int checks = 0;

    // behavioural reference model state
    bit         m_en, m_master, m_cpol, m_cke, m_active;
    int         m_t;
    logic [7:0] m_tx;
    logic [7:0] peer_a = 8'h00, peer_b = 8'h00;
    logic [7:0] v;

    always #5 clk = ~clk;

    assign sdi = m_master ? sdi_m : slv_sdi;

    spi_port i_spi_port (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq),
        .sck_i     (sck_i),
        .sck_o     (sck_o),
        .sck_oe    (sck_oe),
        .sdi       (sdi),
        .sdo       (sdo)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison of the serial pins against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (m_active) begin
                check("R4 sck level", {7'd0, sck_o},
                      {7'd0, m_cpol ^ (m_cke ? ((m_t % 4) >= 2) : ((m_t % 4) < 2))});
                check("R3 sdo bit", {7'd0, sdo}, {7'd0, m_tx[7 - m_t / 4]});
                sdi_m = ((m_t % 4) < 2) ? peer_a[7 - m_t / 4] : peer_b[7 - m_t / 4];
                m_t++;
                if (m_t == 32) m_active = 1'b0;
            end else begin
                check("R3 idle level", {7'd0, sck_o}, {7'd0, m_cpol});
            end
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        #1;
        if (a == 2'd0) begin m_en = d[0]; m_master = d[1]; m_cpol = d[2]; end
        if (a == 2'd1) m_cke = d[6];
        if (a == 2'd2 && m_en && m_master && !m_active) begin
            m_active = 1'b1; m_t = 0; m_tx = d;
        end
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #2;
        d = rdata;
        @(posedge clk);
        #1;
        rd = 1'b0;
    endtask

    task automatic wait_done();
        while (m_active) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic slave_xfer(input logic pol, input logic ph, input logic [7:0] tx, input logic [7:0] rx);
        for (int k = 0; k < 8; k++) begin
            if (ph) begin
                slv_sdi = rx[7 - k];
                repeat (8) @(negedge clk);
                check("R6 slave sdo", {7'd0, sdo}, {7'd0, tx[7 - k]});
                sck_i = ~pol;
                repeat (8) @(negedge clk);
                sck_i = pol;
            end else begin
                sck_i = ~pol;
                slv_sdi = rx[7 - k];
                repeat (8) @(negedge clk);
                check("R6 slave sdo", {7'd0, sdo}, {7'd0, tx[7 - k]});
                sck_i = pol;
                repeat (8) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 sck_o", {7'd0, sck_o}, 8'h00);
        check("R1 sdo", {7'd0, sdo}, 8'h00);
        bus_read(2'd0, v); check("R1 ctrl", v, 8'h00);
        bus_read(2'd1, v); check("R1 status", v, 8'h00);
        bus_read(2'd2, v); check("R1 data", v, 8'h00);

        // R2 register access
        bus_write(2'd0, 8'hA6);
        bus_read(2'd0, v); check("R2 ctrl readback", v, 8'hA6);
        check("R3 idle follows cpol", {7'd0, sck_o}, 8'h01);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, v); check("R2 status writable bits", v, 8'hC0);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, v); check("R2 status cleared", v, 8'h00);

        // R3 disabled port: data write starts nothing
        bus_write(2'd0, 8'h02);
        bus_write(2'd2, 8'h33);
        repeat (40) @(negedge clk);
        check("R3 no transfer irq", {7'd0, irq}, 8'h00);
        bus_read(2'd1, v); check("R3 no transfer bf", v, 8'h00);
        bus_read(2'd2, v); check("R10 buffer loaded", v, 8'h33);

        // R5 mid-bit capture, cke=0 cpol=0
        bus_write(2'd0, 8'h03);
        bus_write(2'd1, 8'h00);
        peer_a = 8'h3C; peer_b = 8'hC3;
        bus_write(2'd2, 8'hA5);
        bus_read(2'd2, v); check("R10 write visible in buffer", v, 8'hA5);
        wait_done();
        bus_read(2'd1, v); check("R7 bf set", v, 8'h01);
        check("R7 irq set", {7'd0, irq}, 8'h01);
        bus_read(2'd2, v); check("R5 mid-bit byte", v, 8'h3C);
        bus_read(2'd1, v); check("R8 read clears bf", v, 8'h00);
        check("R8 irq survives read", {7'd0, irq}, 8'h01);
        bus_read(2'd0, v); check("R8 irq in ctrl", v, 8'h13);
        bus_write(2'd0, 8'h03);
        check("R8 irq cleared by write", {7'd0, irq}, 8'h00);

        // R5 end-of-bit capture, cke=1 cpol=1
        bus_write(2'd0, 8'h07);
        bus_write(2'd1, 8'hC0);
        peer_a = 8'h1E; peer_b = 8'hE1;
        bus_write(2'd2, 8'h5A);
        wait_done();
        bus_read(2'd2, v); check("R5 end-of-bit byte", v, 8'hE1);
        bus_write(2'd0, 8'h07);

        // R9 overflow
        peer_a = 8'h81; peer_b = 8'h81;
        bus_write(2'd2, 8'h11);
        wait_done();
        peer_a = 8'h7E; peer_b = 8'h7E;
        bus_write(2'd2, 8'h22);
        wait_done();
        bus_read(2'd0, v); check("R9 ovf and irq set", v, 8'h1F);
        bus_read(2'd1, v); check("R9 bf still set", v, 8'hC1);
        bus_read(2'd2, v); check("R9 buffer kept", v, 8'h22);
        bus_write(2'd0, 8'h07);
        bus_read(2'd0, v); check("R9 ovf cleared by write", v, 8'h07);

        // R10 write during a running transfer is ignored
        peer_a = 8'h55; peer_b = 8'h55;
        bus_write(2'd2, 8'hF0);
        repeat (6) @(negedge clk);
        bus_write(2'd2, 8'h0F);
        wait_done();
        bus_read(2'd2, v); check("R10 busy write ignored", v, 8'h55);
        bus_write(2'd0, 8'h07);

        // R6 slave, cke=0 cpol=0, smp=1 ignored
        sck_i = 1'b0;
        bus_write(2'd0, 8'h01);
        bus_write(2'd1, 8'h80);
        bus_write(2'd2, 8'h96);
        slave_xfer(1'b0, 1'b0, 8'h96, 8'h4B);
        bus_read(2'd1, v); check("R6 slave bf", v, 8'h81);
        bus_read(2'd2, v); check("R6 slave byte cke0", v, 8'h4B);
        check("R7 slave irq", {7'd0, irq}, 8'h01);
        bus_write(2'd0, 8'h01);

        // R6 slave, cke=1 cpol=1
        sck_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_write(2'd0, 8'h05);
        bus_write(2'd1, 8'h40);
        bus_write(2'd2, 8'h69);
        slave_xfer(1'b1, 1'b1, 8'h69, 8'hD2);
        bus_read(2'd2, v); check("R6 slave byte cke1", v, 8'hD2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule